// File: doc/BRIEF.md
# Write-Through Data Cache with Periphery Guard

This block is the control and checking logic of a small direct-mapped data cache that writes every store straight through to backing memory. No line ever holds data that memory lacks, so any error found in the cache can be resolved by dropping the line and fetching it again. Each stored word carries an even parity bit. Parity alone cannot catch a fault in the cache periphery, such as the row decoder or the word lines. Such a fault can write a whole word with matching parity into the wrong place, or into two places at once.

A guard therefore watches the word-line vector on every access. It flags an error when the number of active lines is not exactly one. It also flags an error when the single active line does not encode back to the requested index. On such an error the requested line and every line that was actually driven are marked invalid, and the access is treated as a miss. Two fault-injection masks arrive with each request and model upsets. One is XORed onto the decoded word-line vector. The other is XORed onto the data word written into the array.

Requests are taken one at a time. Read hits answer from the array. Misses issue a read to backing memory and fill the line. Writes allocate the line and also emit one write-through beat.

Top module: `wt_cache_guard`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid, mem_wr_valid and mem_rd_req are 0, and every line is invalid, so the first read of any address misses.
- R2: A read accepted at clock edge E0 that hits drives rsp_valid for exactly one cycle after edge E0+2, with the stored word on rsp_data and no memory read.
- R3: A read miss raises mem_rd_req with mem_rd_addr equal to the request address and holds both until mem_rd_valid. The response then carries mem_rd_data, and the line is filled so that the next read of that address hits.
- R4: The line index is req_addr[IDX_W-1:0] and the tag is the remaining upper address bits. A read whose tag differs from the stored tag at that index misses.
- R5: A write accepted at edge E0 drives mem_wr_valid for one cycle after edge E0+1, with the request address and the unmodified write data. It also allocates the line, so a later read hits and returns the written data.
- R6: Each stored word carries even parity computed over the write data before fault injection. A read whose stored data fails parity is a miss and returns the correct word from memory.
- R7: The guard flags a word-line error when the driven word-line vector (the one-hot decode XOR flt_wl_mask) has zero active bits or more than one active bit. When no word line is active, the array is not written.
- R8: The guard flags an index error when exactly one word line is active but it is not the line of the requested index. A write in that case lands on the driven line.
- R9: On a guard error, the requested line and every driven line are invalidated, and a read with a guard error is answered as a miss from memory.
- R10: req_ready is 0 from request acceptance until the operation completes, including the whole wait for memory during a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| flt_wl_mask | input | 2**IDX_W | Fault mask XORed onto the decoded word lines |
| flt_data_mask | input | DATA_W | Fault mask XORed onto the data stored by a write |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | DATA_W | Read data |
| mem_wr_valid | output | 1 | Write-through beat |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |
| mem_rd_req | output | 1 | Refill request, held until served |
| mem_rd_addr | output | ADDR_W | Refill address |
| mem_rd_valid | input | 1 | Refill data present |
| mem_rd_data | input | DATA_W | Refill data |

## Verification
A cold read and then a warm read of every one of the 64 lines separate the miss path from the hit path, and show that fill and index decode cover the whole array. Aliasing addresses that share an index but not a tag check tag comparison. Writing every line followed by a read-back checks allocation and the write-through beat. Flipping each of the 32 data bits in turn checks that parity catches every single-bit corruption. Word-line masks that produce two active lines, no active line, and one misplaced line are applied on both writes and reads. The misplaced case is the one that parity cannot detect. Each is followed by reads of both the intended line and the victim line, which confirms the invalidation at the ports.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD1,
    ST_RD2,
    ST_FILL
  } wtc_state_e;

  function automatic logic even_par(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/wtc_wl_drive.sv
module wtc_wl_drive #(
  parameter int IDX_W = 6,
  localparam int LINES = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [LINES-1:0] flt_mask,
  output logic [LINES-1:0] wl
);
  for (genvar g = 0; g < LINES; g++) begin : g_row
    assign wl[g] = (idx == IDX_W'(g)) ^ flt_mask[g];
  end
endmodule

// File: rtl/wtc_wl_guard.sv
module wtc_wl_guard #(
  parameter int IDX_W = 6,
  localparam int LINES = 1 << IDX_W,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [LINES-1:0] wl,
  input  logic [IDX_W-1:0] idx,
  output logic             cnt_err,
  output logic             idx_err,
  output logic             any_line,
  output logic [IDX_W-1:0] enc
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LINES; i++) begin
      cnt = cnt + CNT_W'(wl[i]);
    end
  end

  always_comb begin
    enc = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (wl[i]) enc = IDX_W'(i);
    end
  end

  assign any_line = |wl;
  assign cnt_err  = (cnt != CNT_W'(1));
  assign idx_err  = (cnt == CNT_W'(1)) && (enc != idx);
endmodule

// File: rtl/wtc_line_array.sv
module wtc_line_array #(
  parameter int ENT_W = 37,
  parameter int IDX_W = 6,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] ram [LINES];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end

  // R10: one operation at a time, so the ports are never used together
  a_r10_port_excl: assert property (@(posedge clk) disable iff (rst) !(we && re));
endmodule

// File: rtl/wt_cache_guard.sv
module wt_cache_guard
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int ENT_W = TAG_W + 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LINES-1:0]  flt_wl_mask,
  input  logic [DATA_W-1:0] flt_data_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data
);
  wtc_state_e        st;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic [LINES-1:0]  s_wlmask;
  logic [DATA_W-1:0] s_dmask;
  logic [LINES-1:0]  valid;

  logic [IDX_W-1:0]  s_idx;
  logic [TAG_W-1:0]  s_tag;
  logic [LINES-1:0]  idx_oh;
  logic [LINES-1:0]  wl;
  logic              cnt_err, idx_err, any_line, perr;
  logic [IDX_W-1:0]  enc;

  logic              arr_we, arr_re;
  logic [IDX_W-1:0]  arr_waddr;
  logic [ENT_W-1:0]  arr_wdata, arr_rdata;

  logic [TAG_W-1:0]  e_tag;
  logic              e_par;
  logic [DATA_W-1:0] e_data;
  logic              par_ok, hit;

  assign s_idx  = s_addr[IDX_W-1:0];
  assign s_tag  = s_addr[ADDR_W-1:IDX_W];
  assign idx_oh = LINES'(1) << s_idx;

  wtc_wl_drive #(.IDX_W(IDX_W)) u_drive (
    .idx      (s_idx),
    .flt_mask (s_wlmask),
    .wl       (wl)
  );

  wtc_wl_guard #(.IDX_W(IDX_W)) u_guard (
    .wl       (wl),
    .idx      (s_idx),
    .cnt_err  (cnt_err),
    .idx_err  (idx_err),
    .any_line (any_line),
    .enc      (enc)
  );

  assign perr = cnt_err | idx_err;

  // array port control: writes follow the driven word line, fills use the clean index
  assign arr_re    = (st == ST_RD1);
  assign arr_we    = ((st == ST_WR) && any_line) || ((st == ST_FILL) && mem_rd_valid);
  assign arr_waddr = (st == ST_FILL) ? s_idx : enc;
  assign arr_wdata = (st == ST_FILL)
                   ? {s_tag, ^mem_rd_data, mem_rd_data}
                   : {s_tag, ^s_wdata, s_wdata ^ s_dmask};

  wtc_line_array #(.ENT_W(ENT_W), .IDX_W(IDX_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .re    (arr_re),
    .raddr (enc),
    .rdata (arr_rdata)
  );

  assign e_data = arr_rdata[DATA_W-1:0];
  assign e_par  = arr_rdata[DATA_W];
  assign e_tag  = arr_rdata[ENT_W-1:DATA_W+1];
  assign par_ok = ((^e_data) == e_par);
  assign hit    = valid[s_idx] && (e_tag == s_tag) && par_ok && !perr;

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      s_addr       <= '0;
      s_wdata      <= '0;
      s_wlmask     <= '0;
      s_dmask      <= '0;
      valid        <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_wr_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            s_addr   <= req_addr;
            s_wdata  <= req_wdata;
            s_wlmask <= flt_wl_mask;
            s_dmask  <= flt_data_mask;
            st       <= req_we ? ST_WR : ST_RD1;
          end
        end
        ST_WR: begin
          mem_wr_valid <= 1'b1;
          mem_wr_addr  <= s_addr;
          mem_wr_data  <= s_wdata;
          if (perr) valid <= valid & ~wl & ~idx_oh;
          else      valid <= valid | idx_oh;
          st <= ST_IDLE;
        end
        ST_RD1: st <= ST_RD2;
        ST_RD2: begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= e_data;
            st        <= ST_IDLE;
          end else begin
            if (perr) valid <= valid & ~wl & ~idx_oh;
            else      valid <= valid & ~idx_oh;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= s_addr;
            st          <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_valid) begin
            mem_rd_req <= 1'b0;
            valid      <= valid | idx_oh;
            rsp_valid  <= 1'b1;
            rsp_data   <= mem_rd_data;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a response is a single-cycle pulse
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R3: refill request and address hold until served
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R10: never ready while a refill is outstanding
  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

  // R5: an accepted write produces a write-through beat two edges later
  a_r5_wt_beat: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_we) |-> ##2 mem_wr_valid);

  // R9: a faulty write leaves no driven line valid
  a_r9_inval: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WR && perr) |=> ((valid & $past(wl)) == '0));
endmodule

// File: tb/sim_wt_cache_guard.sv
module sim_wt_cache_guard;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [LINES-1:0]  flt_wl_mask = '0;
  logic [DATA_W-1:0] flt_data_mask = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_wr_valid;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;
  logic              mem_rd_req;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rd_valid;
  logic [DATA_W-1:0] mem_rd_data;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] mdl [DEPTH];
  logic [DATA_W-1:0] expv [DEPTH];
  int                lat_cnt;

  always #10 clk = ~clk;

  wt_cache_guard #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .flt_wl_mask(flt_wl_mask), .flt_data_mask(flt_data_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DATA_W-1:0] init_word(input int a);
    return DATA_W'(a) * 32'h9E37_79B1 + 32'h0135_7ACE;
  endfunction

  // backing memory model
  always @(posedge clk) begin
    if (rst) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
      lat_cnt      <= 0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (mem_rd_req && !mem_rd_valid) begin
        if (lat_cnt == LAT) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mdl[mem_rd_addr];
          lat_cnt      <= 0;
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
      if (mem_wr_valid) mdl[mem_wr_addr] <= mem_wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                       input logic [LINES-1:0] wlm, input logic [DATA_W-1:0] dm);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid     = 1'b1;
    req_we        = we;
    req_addr      = ADDR_W'(addr);
    req_wdata     = wd;
    flt_wl_mask   = wlm;
    flt_data_mask = dm;
    @(negedge clk);
    req_valid     = 1'b0;
    flt_wl_mask   = '0;
    flt_data_mask = '0;
  endtask

  // write; beat is visible one negedge after the acceptance negedge
  task automatic do_write(input int addr, input logic [DATA_W-1:0] wd,
                          input logic [LINES-1:0] wlm, input logic [DATA_W-1:0] dm,
                          input string req);
    issue(1'b1, addr, wd, wlm, dm);
    chk(!req_ready, "R10", "ready during write", DATA_W'(req_ready), 0);
    @(negedge clk);
    chk(mem_wr_valid && mem_wr_addr == ADDR_W'(addr) && mem_wr_data == wd,
        req, "write-through beat", mem_wr_data, wd);
    expv[addr] = wd;
  endtask

  // read; reports whether memory was read and the negedge count to the response
  task automatic do_read(input int addr, input logic [LINES-1:0] wlm,
                         input bit exp_miss, input string req);
    int  n;
    bit  missed;
    bit  busy_bad;
    issue(1'b0, addr, '0, wlm, '0);
    n = 0;
    missed = 1'b0;
    busy_bad = 1'b0;
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
      if (mem_rd_req) begin
        missed = 1'b1;
        if (req_ready) busy_bad = 1'b1;
        if (mem_rd_addr != ADDR_W'(addr)) busy_bad = 1'b1;
      end
    end
    chk(rsp_valid, req, "response arrived", DATA_W'(rsp_valid), 1);
    chk(rsp_data == expv[addr], req, "read data", rsp_data, expv[addr]);
    chk(missed == exp_miss, req, "miss indication", DATA_W'(missed), DATA_W'(exp_miss));
    if (!exp_miss)
      chk(n == 2, "R2", "hit latency", DATA_W'(n), 2);
    else
      chk(!busy_bad, "R10", "busy and address during refill", DATA_W'(busy_bad), 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mdl[a]  = init_word(a);
      expv[a] = init_word(a);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1, "R1", "req_ready after reset", DATA_W'(req_ready), 1);
    chk(!rsp_valid && !mem_wr_valid && !mem_rd_req, "R1", "strobes idle after reset",
        {29'b0, rsp_valid, mem_wr_valid, mem_rd_req}, 0);

    // R1, R3: cold reads miss; R2: warm reads hit
    for (int i = 0; i < LINES; i++) begin
      do_read(i + LINES, '0, 1'b1, "R3");
      do_read(i + LINES, '0, 1'b0, "R2");
    end

    // R4: aliasing tag misses and evicts
    for (int i = 0; i < LINES; i += 7) begin
      do_read(i + 5 * LINES, '0, 1'b1, "R4");
      do_read(i + LINES, '0, 1'b1, "R4");
    end

    // R5: write-through and allocation on every line
    for (int i = 0; i < LINES; i++) begin
      do_write(i + 2 * LINES, init_word(i) ^ 32'hA5A5_0F0F, '0, '0, "R5");
      do_read(i + 2 * LINES, '0, 1'b0, "R5");
    end

    // R6: every single-bit data corruption is caught by parity
    for (int b = 0; b < DATA_W; b++) begin
      do_write(10 + 2 * LINES, 32'h1000_0000 + DATA_W'(b), '0, DATA_W'(1) << b, "R5");
      do_read(10 + 2 * LINES, '0, 1'b1, "R6");
      do_read(10 + 2 * LINES, '0, 1'b0, "R6");
    end

    // R7, R9: write drives two word lines -> both lines invalidated
    for (int k = 1; k < 8; k++) begin
      int a;
      int b;
      a = (k * 5) % LINES;
      b = (k * 11 + 3) % LINES;
      do_read(a + 2 * LINES, '0, 1'b0, "R2");
      do_read(b + 2 * LINES, '0, 1'b0, "R2");
      do_write(a + 2 * LINES, 32'h7700_0000 + DATA_W'(k), LINES'(1) << b, '0, "R5");
      do_read(a + 2 * LINES, '0, 1'b1, "R7");
      do_read(b + 2 * LINES, '0, 1'b1, "R9");
    end

    // R7: no word line driven -> nothing written, line invalidated
    for (int k = 0; k < 4; k++) begin
      int a;
      a = k * 13 + 1;
      do_write(a + 2 * LINES, 32'h5500_0000 + DATA_W'(k), LINES'(1) << a, '0, "R5");
      do_read(a + 2 * LINES, '0, 1'b1, "R7");
    end

    // R8, R9: single misplaced word line corrupts a victim; both invalidated
    for (int k = 0; k < 4; k++) begin
      int a;
      int b;
      a = k * 9 + 4;
      b = k * 9 + 30;
      do_read(b + 2 * LINES, '0, 1'b0, "R2");
      do_write(a + 2 * LINES, 32'h3300_0000 + DATA_W'(k),
               (LINES'(1) << a) | (LINES'(1) << b), '0, "R5");
      do_read(b + 2 * LINES, '0, 1'b1, "R8");
      do_read(a + 2 * LINES, '0, 1'b1, "R9");
    end

    // R9: faulty read answered from memory, victim line invalidated
    for (int k = 0; k < 4; k++) begin
      int a;
      int b;
      a = k * 7 + 2;
      b = k * 7 + 40;
      do_read(a + 2 * LINES, '0, 1'b0, "R2");
      do_read(b + 2 * LINES, '0, 1'b0, "R2");
      do_read(a + 2 * LINES, LINES'(1) << b, 1'b1, "R9");
      do_read(b + 2 * LINES, '0, 1'b1, "R9");
      do_read(a + 2 * LINES, '0, 1'b0, "R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule